// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address front end of a synchronous burst SRAM. On every rising clock edge it samples an external word address, two active-low address strobes, an active-low advance input and three chip-enable inputs. From these it produces the word address that drives the memory array, along with a registered select flag. A strobe loads the external address into the address register and clears the burst counter. On each later cycle with advance asserted, the 2-bit counter steps once. The low address bits then follow either a linear (wrap modulo 4) or an interleaved (start XOR count) sequence, chosen by a static order input.

A new address can be loaded on every cycle, so bursting is optional. The two strobes differ in one way. The processor-side strobe is honoured only when the first chip enable is active, and it wins when both strobes fire together. A pulse and a source flag report each accepted burst start. The order input is resolved so that a pin left open selects the interleaved order.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held, and until the first accepted strobe, `word_addr` is 0 and `selected`, `start_pulse` and `start_src` are 0.
- R2: A low `strb_ctrl_n` at a rising edge loads `addr_in`. After that edge `word_addr` equals the loaded address and `start_pulse` is 1 for one cycle. If `strb_proc_n` was not also accepted, `start_src` is 0.
- R3: A low `strb_proc_n` with `ce1_n` low loads `addr_in` the same way, and `start_src` is 1 after the edge.
- R4: When both strobes are accepted in the same cycle, the processor-side strobe wins: `start_src` is 1.
- R5: When `ce1_n` is high, a low `strb_proc_n` is ignored: with `strb_ctrl_n` high, `word_addr`, `selected` and `start_src` keep their values and `start_pulse` is 0.
- R6: With no strobe accepted, a low `adv_n` steps the burst count by one (modulo 4) at the edge. A strobe overrides advance and resets the count to 0.
- R7: With `order_sel` = 0 (linear), `word_addr[1:0]` equals (loaded low bits + count) mod 4.
- R8: With `order_sel` = 1 (interleaved), `word_addr[1:0]` equals the loaded low bits XOR the count.
- R9: With no strobe accepted and `adv_n` high, `word_addr` holds its value.
- R10: Bits above bit 1 of `word_addr` change only on an accepted strobe.
- R11: On each accepted strobe, `selected` becomes 1 exactly when `ce1_n` = 0, `ce2` = 1 and `ce3_n` = 0. Between strobes it holds, so a deselect shows one cycle after it is sampled.
- R12: Strobes on consecutive cycles each load their own address, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_in | input | ADDR_W | External word address |
| strb_proc_n | input | 1 | Processor-side address strobe, active low, gated by `ce1_n` |
| strb_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| order_sel | input | 1 | 0 = linear burst order, 1 or open = interleaved |
| word_addr | output | ADDR_W | Internal word address to the array |
| selected | output | 1 | Registered device select |
| start_pulse | output | 1 | One-cycle flag after an accepted strobe |
| start_src | output | 1 | Source of the last accepted strobe: 1 processor side, 0 controller side |

## Verification
Three things can land on the same edge: a strobe, an advance, and the second strobe. A strobe must override an advance, and the processor-side strobe must override the controller-side one unless `ce1_n` gates it off. Directed cycles drive these overlaps with advance held low. The random phase drives all controls each cycle at densities that make such overlaps frequent. A bench model applies the priorities on its own, and each cycle it compares the address, the select flag and the start flags against that model. Collisions that land mid-burst show up as a count that resets to 0 rather than stepping.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic {
    SRC_CTRL = 1'b0,
    SRC_PROC = 1'b1
  } start_src_e;

  typedef struct packed {
    logic       load;
    start_src_e src;
  } strobe_dec_t;

endpackage

// File: rtl/bsq_mode_pin.sv
module bsq_mode_pin (
  input  logic order_pin,
  output logic interleave
);

  // Only a firm low selects linear order; an open pin reads as interleaved.
  always_comb begin
    interleave = (order_pin === 1'b0) ? 1'b0 : 1'b1;
  end

endmodule

// File: rtl/bsq_strobe_arb.sv
module bsq_strobe_arb
  import bsq_pkg::*;
(
  input  logic        strb_proc_n,
  input  logic        strb_ctrl_n,
  input  logic        ce1_n,
  output strobe_dec_t dec
);

  logic proc_ok;
  logic ctrl_ok;

  always_comb begin
    proc_ok  = ~strb_proc_n & ~ce1_n;
    ctrl_ok  = ~strb_ctrl_n;
    dec.load = proc_ok | ctrl_ok;
    dec.src  = proc_ok ? SRC_PROC : SRC_CTRL;
  end

endmodule

// File: rtl/bsq_chip_sel.sv
module bsq_chip_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  output logic selected
);

  logic sel_q;
  logic sel_d;
  logic sel_en;

  always_comb begin
    sel_en = load;
    sel_d  = ~ce1_n & ce2 & ~ce3_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign selected = sel_q;

endmodule

// File: rtl/bsq_burst_ctr.sv
module bsq_burst_ctr #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr
);

  localparam int UP_W = ADDR_W - CNT_W;

  logic [UP_W-1:0]  upper_q, upper_d;
  logic [CNT_W-1:0] base_q,  base_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;
  logic             reg_en;
  logic [CNT_W-1:0] low_lin;
  logic [CNT_W-1:0] low_ilv;

  always_comb begin
    reg_en = load | adv;
    upper_d = upper_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    if (load) begin
      upper_d = addr_in[ADDR_W-1:CNT_W];
      base_d  = addr_in[CNT_W-1:0];
      cnt_d   = '0;
    end else if (adv) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else if (reg_en) begin
      upper_q <= upper_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
    end
  end

  assign low_lin = base_q + cnt_q;

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign low_ilv[b] = base_q[b] ^ cnt_q[b];
  end

  assign word_addr = {upper_q, (interleave ? low_ilv : low_lin)};

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] word_addr,
  output logic              selected,
  output logic              start_pulse,
  output logic              start_src
);

  logic [SYNC_N-1:0] rst_pipe_q;
  logic              rst_sync_n;
  strobe_dec_t       dec;
  logic              interleave;
  logic              pulse_q, pulse_d;
  start_src_e        src_q, src_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[SYNC_N-1];

  bsq_mode_pin u_mode (
    .order_pin  (order_sel),
    .interleave (interleave)
  );

  bsq_strobe_arb u_arb (
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .ce1_n       (ce1_n),
    .dec         (dec)
  );

  bsq_chip_sel u_sel (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (dec.load),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .selected (selected)
  );

  bsq_burst_ctr #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (dec.load),
    .adv        (~adv_n),
    .interleave (interleave),
    .addr_in    (addr_in),
    .word_addr  (word_addr)
  );

  always_comb begin
    pulse_d = dec.load;
    src_d   = dec.load ? dec.src : src_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pulse_q <= 1'b0;
      src_q   <= SRC_CTRL;
    end else begin
      pulse_q <= pulse_d;
      src_q   <= src_d;
    end
  end

  assign start_pulse = pulse_q;
  assign start_src   = src_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_i,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strb_proc_n,
  input logic              strb_ctrl_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] word_addr,
  input logic              selected,
  input logic              start_pulse,
  input logic              start_src
);

  logic acc;
  assign acc = ~strb_ctrl_n | (~strb_proc_n & ~ce1_n);

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_i)
    acc |=> (word_addr == $past(addr_in) && start_pulse)) else $error("load"); // R2

  AST_PROC_SRC: assert property (@(posedge clk) disable iff (!rst_i)
    (!strb_proc_n && !ce1_n) |=> start_src) else $error("proc src"); // R4

  AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_i)
    (strb_ctrl_n && ce1_n) |=> (!start_pulse && $stable(selected) && $stable(start_src)))
    else $error("gated"); // R5

  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_i)
    !acc |=> $stable(word_addr[ADDR_W-1:CNT_W])) else $error("upper"); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    (!acc && adv_n) |=> ($stable(word_addr) || order_sel != $past(order_sel)))
    else $error("hold"); // R9

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_i)
    (!acc && !adv_n && !order_sel) |=>
      (order_sel || word_addr[CNT_W-1:0] == CNT_W'($past(word_addr[CNT_W-1:0]) + 1'b1)))
    else $error("linear step"); // R7

  AST_SEL_DECODE: assert property (@(posedge clk) disable iff (!rst_i)
    acc |=> (selected == $past(!ce1_n && ce2 && !ce3_n))) else $error("select"); // R11

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_i       (rst_sync_n),
  .addr_in     (addr_in),
  .strb_proc_n (strb_proc_n),
  .strb_ctrl_n (strb_ctrl_n),
  .adv_n       (adv_n),
  .ce1_n       (ce1_n),
  .ce2         (ce2),
  .ce3_n       (ce3_n),
  .order_sel   (order_sel),
  .word_addr   (word_addr),
  .selected    (selected),
  .start_pulse (start_pulse),
  .start_src   (start_src)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          strb_proc_n, strb_ctrl_n, adv_n;
  logic          ce1_n, ce2, ce3_n, order_sel;
  logic [AW-1:0] word_addr;
  logic          selected, start_pulse, start_src;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state
  logic [AW-3:0] m_up;
  logic [1:0]    m_base, m_cnt;
  logic          m_sel, m_pulse, m_src;

  always #2.5 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk, .rst_n, .addr_in, .strb_proc_n, .strb_ctrl_n, .adv_n,
    .ce1_n, .ce2, .ce3_n, .order_sel,
    .word_addr, .selected, .start_pulse, .start_src
  );

  function automatic logic [AW-1:0] exp_addr(input logic ord);
    logic [1:0] lo;
    lo = ord ? (m_base ^ m_cnt) : 2'(m_base + m_cnt);
    return {m_up, lo};
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " addr"}, word_addr, exp_addr(order_sel));
    chk({tag, " sel R11"}, AW'(selected), AW'(m_sel));
    chk({tag, " pulse"}, AW'(start_pulse), AW'(m_pulse));
    chk({tag, " src"}, AW'(start_src), AW'(m_src));
  endtask

  // drive at negedge, advance one edge, update model, sample at next negedge
  task automatic step(input logic [AW-1:0] a, input logic pn, input logic cn,
                      input logic av, input logic e1, input logic e2, input logic e3,
                      input logic ord, input string tag);
    logic acc, pacc;
    addr_in = a; strb_proc_n = pn; strb_ctrl_n = cn; adv_n = av;
    ce1_n = e1; ce2 = e2; ce3_n = e3; order_sel = ord;
    @(posedge clk);
    pacc = !pn && !e1;
    acc  = pacc || !cn;
    m_pulse = acc;
    if (acc) begin
      m_up = a[AW-1:2]; m_base = a[1:0]; m_cnt = 2'd0;
      m_sel = !e1 && e2 && !e3;
      m_src = pacc;
    end else if (!av) begin
      m_cnt = m_cnt + 2'd1;
    end
    @(negedge clk);
    chk_all(tag);
  endtask

  initial begin
    #(5 * 200000);
    $display("FAIL watchdog R1 actual running expected finished");
    errors++;
    checks++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de));
    rst_n = 1'b0;
    addr_in = '0; strb_proc_n = 1; strb_ctrl_n = 1; adv_n = 1;
    ce1_n = 1; ce2 = 0; ce3_n = 1; order_sel = 0;
    m_up = '0; m_base = '0; m_cnt = '0; m_sel = 0; m_pulse = 0; m_src = 0;
    repeat (3) @(negedge clk);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1 after release");

    // R2 controller strobe, then linear burst R7/R6 from low bits 2
    step(20'hABCD2, 1, 0, 1, 1, 1, 0, 0, "R2 ctrl load");
    for (int i = 0; i < 5; i++) step('0, 1, 1, 0, 1, 1, 0, 0, "R7 linear adv R6");
    step('0, 1, 1, 1, 1, 1, 0, 0, "R9 hold R10");
    // R3 processor strobe, interleaved R8 from low bits 1
    step(20'h12341, 0, 1, 1, 0, 1, 0, 1, "R3 proc load");
    for (int i = 0; i < 5; i++) step('0, 1, 1, 0, 0, 1, 0, 1, "R8 interleave adv");
    // R4 both strobes, R6 strobe overrides advance
    step(20'h55553, 0, 0, 0, 0, 1, 0, 1, "R4 both strobes R6");
    // R5 processor strobe gated off
    step(20'hFFFFC, 0, 1, 1, 1, 1, 0, 1, "R5 gated proc");
    // R11 deselect via ctrl strobe and each enable
    step(20'h00010, 1, 0, 1, 0, 0, 0, 0, "R11 ce2 low");
    step(20'h00020, 1, 0, 1, 0, 1, 1, 0, "R11 ce3 high");
    step(20'h00030, 1, 0, 1, 0, 1, 0, 0, "R11 selected");
    // R12 back-to-back loads
    for (int i = 0; i < 6; i++) step(AW'(i * 32'h11113), (i % 2) == 0, (i % 2) != 0, 0, 0, 1, 0, 0, "R12 back-to-back");

    for (int i = 0; i < 3000; i++) begin
      step(AW'($urandom),
           ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 3) == 0,
           ($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 4) == 0,
           ($urandom % 16) == 0 ? ~order_sel : order_sel, "random R6 R7 R8 R10");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule